// File: doc/BRIEF.md
# Dual Address Breakpoint Comparator

This block is a debug trigger unit that watches a processor's local bus. Every cycle in which a transfer is presented, it compares the transfer address against two independent breakpoint channels. Each channel has a low bound, a high bound and a control word. The control word selects how the address is compared and which transfer attribute bits must also match. A channel flags a hit on its own output pin one clock after the transfer is sampled.

The bus side is an observe-only stream. The transfer-valid strobe qualifies the address and attributes. There is no ready signal, because the comparator never applies back-pressure: every cycle with the valid strobe high is evaluated, and the bus never waits on this block. Configuration arrives through a single-cycle register-write port that carries a 5-bit register index. The hit outputs are plain status pins with no handshake.

The transfer attributes form a 5-bit code, {type[1:0], modifier[2:0]}, where the type occupies bits 4:3 and the modifier occupies bits 2:0. Some example codes:
- 5'b00_001 is a user data access.
- 5'b00_010 is a user code access.
- 5'b00_101 is a supervisor data access.
- 5'b00_110 is a supervisor code access.
- 5'b11_000 is a CPU-space access.
- 5'b11_001 to 5'b11_111 are interrupt acknowledge levels 1 to 7.

Top module: `addr_bp_watch`

## Requirements
- R1: After reset, both channels are disabled, both hit outputs are 0, and every bound register holds zero. Enabling equal mode without writing a bound therefore makes address 0 hit.
- R2: In equal mode (control bits [1:0] = 01), a channel's address condition holds exactly when the transfer address equals its low bound.
- R3: In inside mode (control bits [1:0] = 10), the address condition holds when low <= address <= high. Both bounds are inclusive.
- R4: In outside mode (control bits [1:0] = 11), the address condition holds when address < low or address > high.
- R5: In disabled mode (control bits [1:0] = 00), the channel never hits.
- R6: Control bits [6:2] hold the expected attribute code and bits [11:7] hold a per-bit compare enable, with 1 meaning the bit is compared. A hit needs every enabled attribute bit to equal its expected bit. Attribute bits that are not enabled have no effect.
- R7: A channel's hit output goes high one clock after a cycle in which the valid strobe is high and the channel matches. After any cycle with the valid strobe low, the output is 0.
- R8: The indices are assigned per channel:
  - Channel 0: low bound at index 0x0D, high bound at 0x0C, control word at 0x07.
  - Channel 1: low bound at 0x1D, high bound at 0x1C, control word at 0x17.
  Each write affects only the addressed channel.
- R9: A write to any other index changes no register, so the hit behaviour of both channels stays the same.
- R10: A register write takes effect for transfers sampled in later cycles. A transfer sampled in the same cycle as the write is compared against the previous settings.
- R11: With low greater than high, inside mode never hits and outside mode hits on every address, provided the attribute condition holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | A transfer is present on the bus this cycle |
| bus_addr | input | 32 | Transfer address |
| bus_type | input | 2 | Transfer type code |
| bus_mod | input | 3 | Transfer modifier code |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_idx | input | 5 | Register index of the write |
| cfg_wr_data | input | 32 | Write data |
| bp_hit | output | 2 | Per-channel breakpoint hit, registered |

## Verification
The assertions assume that the control inputs are never X while reset is released. They also assume that the register write port and the bus can be active in the same cycle, which the block must order correctly. The stimulus drives every input at the falling clock edge, so writes and transfers are always stable at the sampling edge. It holds unused inputs at zero rather than X. Beyond the valid indices, the stimulus also issues writes to neighbouring indices so that the stability check on the registers is exercised.

// File: rtl/addr_bp_pkg.sv
package addr_bp_pkg;

  typedef enum logic [1:0] {
    BP_OFF = 2'b00,
    BP_EQ  = 2'b01,
    BP_IN  = 2'b10,
    BP_OUT = 2'b11
  } bp_mode_e;

  localparam int ATTR_W = 5;
  localparam int IDX_W  = 5;

  // channel 1 register indices sit at channel 0 index plus this offset
  localparam logic [IDX_W-1:0] IDX_CH_STEP = 5'h10;
  localparam logic [IDX_W-1:0] IDX_LO_BASE = 5'h0D;
  localparam logic [IDX_W-1:0] IDX_HI_BASE = 5'h0C;
  localparam logic [IDX_W-1:0] IDX_CT_BASE = 5'h07;

  // control word field positions
  localparam int CT_MODE_LSB = 0;
  localparam int CT_EXP_LSB  = 2;
  localparam int CT_MSK_LSB  = CT_EXP_LSB + ATTR_W;
  localparam int CT_W        = CT_MSK_LSB + ATTR_W;

  function automatic logic [IDX_W-1:0] ch_index(input logic [IDX_W-1:0] base, input int ch);
    return base + ((ch != 0) ? IDX_CH_STEP : '0);
  endfunction

endpackage

// File: rtl/addr_bp_regs.sv
module addr_bp_regs
  import addr_bp_pkg::*;
#(
  parameter int AW  = 32,
  parameter int NCH = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [AW-1:0]                wr_data,
  output logic [NCH-1:0][AW-1:0]       lo,
  output logic [NCH-1:0][AW-1:0]       hi,
  output logic [NCH-1:0][1:0]          mode,
  output logic [NCH-1:0][ATTR_W-1:0]   exp_attr,
  output logic [NCH-1:0][ATTR_W-1:0]   msk_attr
);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [IDX_W-1:0] LO_IDX = ch_index(IDX_LO_BASE, c);
    localparam logic [IDX_W-1:0] HI_IDX = ch_index(IDX_HI_BASE, c);
    localparam logic [IDX_W-1:0] CT_IDX = ch_index(IDX_CT_BASE, c);

    logic sel_lo, sel_hi, sel_ct;
    assign sel_lo = wr_en && (wr_idx == LO_IDX);
    assign sel_hi = wr_en && (wr_idx == HI_IDX);
    assign sel_ct = wr_en && (wr_idx == CT_IDX);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo[c]       <= '0;
        hi[c]       <= '0;
        mode[c]     <= BP_OFF;
        exp_attr[c] <= '0;
        msk_attr[c] <= '0;
      end else begin
        if (sel_lo) lo[c] <= wr_data;
        if (sel_hi) hi[c] <= wr_data;
        if (sel_ct) begin
          mode[c]     <= wr_data[CT_MODE_LSB +: 2];
          exp_attr[c] <= wr_data[CT_EXP_LSB +: ATTR_W];
          msk_attr[c] <= wr_data[CT_MSK_LSB +: ATTR_W];
        end
      end
    end
  end

endmodule

// File: rtl/addr_bp_cmp.sv
module addr_bp_cmp
  import addr_bp_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [1:0]        mode,
  input  logic [AW-1:0]     lo,
  input  logic [AW-1:0]     hi,
  input  logic [AW-1:0]     addr,
  output logic              addr_ok
);

  logic eq_lo, ge_lo, le_hi, in_rng;

  assign eq_lo  = (addr == lo);
  assign ge_lo  = (addr >= lo);
  assign le_hi  = (addr <= hi);
  assign in_rng = ge_lo && le_hi;

  always_comb begin
    unique case (bp_mode_e'(mode))
      BP_EQ:   addr_ok = eq_lo;
      BP_IN:   addr_ok = in_rng;
      BP_OUT:  addr_ok = !in_rng;
      default: addr_ok = 1'b0;
    endcase
  end

endmodule

// File: rtl/addr_bp_attr.sv
module addr_bp_attr
  import addr_bp_pkg::*;
(
  input  logic [ATTR_W-1:0] attr,
  input  logic [ATTR_W-1:0] exp_attr,
  input  logic [ATTR_W-1:0] msk_attr,
  output logic              attr_ok
);

  assign attr_ok = ~|((attr ^ exp_attr) & msk_attr);

endmodule

// File: rtl/addr_bp_watch.sv
module addr_bp_watch
  import addr_bp_pkg::*;
#(
  parameter int AW  = 32,
  parameter int NCH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic [AW-1:0]     bus_addr,
  input  logic [1:0]        bus_type,
  input  logic [2:0]        bus_mod,
  input  logic              cfg_wr_en,
  input  logic [IDX_W-1:0]  cfg_wr_idx,
  input  logic [AW-1:0]     cfg_wr_data,
  output logic [NCH-1:0]    bp_hit
);

  logic [NCH-1:0][AW-1:0]     ch_lo, ch_hi;
  logic [NCH-1:0][1:0]        ch_mode;
  logic [NCH-1:0][ATTR_W-1:0] ch_exp, ch_msk;
  logic [ATTR_W-1:0]          bus_attr;
  logic [NCH-1:0]             addr_ok, attr_ok, hit_d;

  assign bus_attr = {bus_type, bus_mod};

  addr_bp_regs #(.AW(AW), .NCH(NCH)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr_en),
    .wr_idx   (cfg_wr_idx),
    .wr_data  (cfg_wr_data),
    .lo       (ch_lo),
    .hi       (ch_hi),
    .mode     (ch_mode),
    .exp_attr (ch_exp),
    .msk_attr (ch_msk)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    addr_bp_cmp #(.AW(AW)) u_cmp (
      .mode    (ch_mode[c]),
      .lo      (ch_lo[c]),
      .hi      (ch_hi[c]),
      .addr    (bus_addr),
      .addr_ok (addr_ok[c])
    );

    addr_bp_attr u_attr (
      .attr     (bus_attr),
      .exp_attr (ch_exp[c]),
      .msk_attr (ch_msk[c]),
      .attr_ok  (attr_ok[c])
    );

    assign hit_d[c] = bus_valid && addr_ok[c] && attr_ok[c];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bp_hit <= '0;
    else        bp_hit <= hit_d;
  end

endmodule

// File: rtl/addr_bp_watch_chk.sv
module addr_bp_watch_chk
  import addr_bp_pkg::*;
#(
  parameter int AW  = 32,
  parameter int NCH = 2
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        bus_valid,
  input logic [AW-1:0]               bus_addr,
  input logic [ATTR_W-1:0]           bus_attr,
  input logic                        cfg_wr_en,
  input logic [IDX_W-1:0]            cfg_wr_idx,
  input logic [NCH-1:0][AW-1:0]      ch_lo,
  input logic [NCH-1:0][AW-1:0]      ch_hi,
  input logic [NCH-1:0][1:0]         ch_mode,
  input logic [NCH-1:0][ATTR_W-1:0]  ch_exp,
  input logic [NCH-1:0][ATTR_W-1:0]  ch_msk,
  input logic [NCH-1:0]              bp_hit
);

  logic bad_idx;
  always_comb begin
    bad_idx = 1'b1;
    for (int c = 0; c < NCH; c++) begin
      if (cfg_wr_idx == ch_index(IDX_LO_BASE, c) ||
          cfg_wr_idx == ch_index(IDX_HI_BASE, c) ||
          cfg_wr_idx == ch_index(IDX_CT_BASE, c)) bad_idx = 1'b0;
    end
  end

  // R7: no transfer, no hit in the next cycle
  a_r7_idle_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> (bp_hit == '0));

  // R9: stray index leaves every register unchanged
  a_r9_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && bad_idx) |=> ($stable(ch_lo) && $stable(ch_hi) && $stable(ch_mode)
                                && $stable(ch_exp) && $stable(ch_msk)));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic attr_match;
    assign attr_match = (((bus_attr ^ ch_exp[c]) & ch_msk[c]) == '0);

    // R5: disabled channel stays quiet
    a_r5_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_mode[c] == BP_OFF) |=> !bp_hit[c]);

    // R2: equal mode misses on any other address
    a_r2_eq_miss: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_mode[c] == BP_EQ && bus_addr != ch_lo[c]) |=> !bp_hit[c]);

    // R3: inclusive range with matching attributes must hit
    a_r3_in_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_mode[c] == BP_IN && bus_valid && attr_match &&
       bus_addr >= ch_lo[c] && bus_addr <= ch_hi[c]) |=> bp_hit[c]);

    // R4: outside mode never hits inside the range
    a_r4_out_miss: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_mode[c] == BP_OUT && bus_addr >= ch_lo[c] && bus_addr <= ch_hi[c]) |=> !bp_hit[c]);

    // R6: an enabled attribute mismatch blocks the hit
    a_r6_attr_block: assert property (@(posedge clk) disable iff (!rst_n)
      !attr_match |=> !bp_hit[c]);
  end

endmodule

bind addr_bp_watch addr_bp_watch_chk #(.AW(AW), .NCH(NCH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_valid  (bus_valid),
  .bus_addr   (bus_addr),
  .bus_attr   (bus_attr),
  .cfg_wr_en  (cfg_wr_en),
  .cfg_wr_idx (cfg_wr_idx),
  .ch_lo      (ch_lo),
  .ch_hi      (ch_hi),
  .ch_mode    (ch_mode),
  .ch_exp     (ch_exp),
  .ch_msk     (ch_msk),
  .bp_hit     (bp_hit)
);

// File: tb/sim_addr_bp_watch.sv
module sim_addr_bp_watch;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [1:0]  bus_type = '0;
  logic [2:0]  bus_mod = '0;
  logic        cfg_wr_en = 1'b0;
  logic [4:0]  cfg_wr_idx = '0;
  logic [31:0] cfg_wr_data = '0;
  logic [1:0]  bp_hit;

  int n_chk = 0;
  int n_err = 0;

  logic [31:0] m_lo [2];
  logic [31:0] m_hi [2];
  logic [1:0]  m_mode [2];
  logic [4:0]  m_exp [2];
  logic [4:0]  m_msk [2];

  always #(CLK_P/2) clk = ~clk;

  addr_bp_watch u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_type(bus_type), .bus_mod(bus_mod), .cfg_wr_en(cfg_wr_en),
    .cfg_wr_idx(cfg_wr_idx), .cfg_wr_data(cfg_wr_data), .bp_hit(bp_hit)
  );

  function automatic logic [31:0] ctl(input logic [1:0] md, input logic [4:0] ex, input logic [4:0] mk);
    return {20'd0, mk, ex, md};
  endfunction

  function automatic bit model_hit(input int c, input logic [31:0] a, input logic [4:0] at);
    bit aok;
    case (m_mode[c])
      2'b01:   aok = (a == m_lo[c]);
      2'b10:   aok = (a >= m_lo[c]) && (a <= m_hi[c]);
      2'b11:   aok = (a < m_lo[c]) || (a > m_hi[c]);
      default: aok = 1'b0;
    endcase
    return aok && (((at ^ m_exp[c]) & m_msk[c]) == 5'd0);
  endfunction

  function automatic logic [1:0] model_vec(input logic [31:0] a, input logic [4:0] at);
    return {model_hit(1, a, at), model_hit(0, a, at)};
  endfunction

  task automatic check(input string rq, input logic [1:0] act, input logic [1:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s: actual %b expected %b", rq, act, expv);
    end
  endtask

  task automatic model_write(input logic [4:0] idx, input logic [31:0] d);
    for (int c = 0; c < 2; c++) begin
      if (idx == (5'h0D + 5'(c * 16))) m_lo[c] = d;
      if (idx == (5'h0C + 5'(c * 16))) m_hi[c] = d;
      if (idx == (5'h07 + 5'(c * 16))) begin
        m_mode[c] = d[1:0];
        m_exp[c]  = d[6:2];
        m_msk[c]  = d[11:7];
      end
    end
  endtask

  task automatic wr(input logic [4:0] idx, input logic [31:0] d);
    @(negedge clk);
    bus_valid   = 1'b0;
    cfg_wr_en   = 1'b1;
    cfg_wr_idx  = idx;
    cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    model_write(idx, d);
  endtask

  task automatic xfer(input string rq, input logic [31:0] a, input logic [4:0] at, input bit v);
    @(negedge clk);
    bus_valid = v;
    bus_addr  = a;
    {bus_type, bus_mod} = at;
    @(negedge clk);
    check(rq, bp_hit, v ? model_vec(a, at) : 2'b00);
  endtask

  initial begin
    for (int c = 0; c < 2; c++) begin
      m_lo[c] = '0; m_hi[c] = '0; m_mode[c] = '0; m_exp[c] = '0; m_msk[c] = '0;
    end
    repeat (3) @(negedge clk);
    check("R1 hit during reset", bp_hit, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 hit after reset", bp_hit, 2'b00);
    xfer("R1 disabled after reset", 32'h0, 5'h00, 1'b1);
    xfer("R5 disabled channel", 32'h1234, 5'h01, 1'b1);

    // R1: bounds are zero after reset, equal mode hits address 0
    wr(5'h07, ctl(2'b01, 5'h00, 5'h00));
    xfer("R1 zero low bound", 32'h0, 5'h0A, 1'b1);
    xfer("R1 zero low bound miss", 32'h1, 5'h0A, 1'b1);

    // R2 R3 R4 R5 R8: sweep all mode pairs over boundary addresses
    wr(5'h0D, 32'h0000_1000); wr(5'h0C, 32'h0000_2000);
    wr(5'h1D, 32'hFFFF_FFF0); wr(5'h1C, 32'hFFFF_FFFF);
    for (int m0 = 0; m0 < 4; m0++) begin
      for (int m1 = 0; m1 < 4; m1++) begin
        wr(5'h07, ctl(2'(m0), 5'h00, 5'h00));
        wr(5'h17, ctl(2'(m1), 5'h00, 5'h00));
        for (int k = 0; k < 12; k++) begin
          logic [31:0] a;
          case (k)
            0: a = 32'h0;          1: a = 32'h0FFF;     2: a = 32'h1000;
            3: a = 32'h1001;       4: a = 32'h1FFF;     5: a = 32'h2000;
            6: a = 32'h2001;       7: a = 32'hFFFF_FFEF; 8: a = 32'hFFFF_FFF0;
            9: a = 32'hFFFF_FFF8;  10: a = 32'hFFFF_FFFF; default: a = 32'h8000_0000;
          endcase
          xfer("R2/R3/R4/R5/R8 mode sweep", a, 5'(k), 1'b1);
        end
      end
    end

    // R7: valid low gives no hit even on a matching address
    wr(5'h07, ctl(2'b10, 5'h00, 5'h00));
    xfer("R7 valid low", 32'h1800, 5'h00, 1'b0);
    xfer("R7 valid high", 32'h1800, 5'h00, 1'b1);
    xfer("R7 valid low again", 32'h1000, 5'h00, 1'b0);

    // R6: all attribute codes against several compare masks
    wr(5'h17, ctl(2'b00, 5'h00, 5'h00));
    for (int mi = 0; mi < 5; mi++) begin
      logic [4:0] mk;
      case (mi)
        0: mk = 5'b00000; 1: mk = 5'b11111; 2: mk = 5'b11000;
        3: mk = 5'b00111; default: mk = 5'b10101;
      endcase
      wr(5'h07, ctl(2'b10, 5'b11_011, mk));
      for (int at = 0; at < 32; at++)
        xfer("R6 attribute qualify", 32'h1500, 5'(at), 1'b1);
    end

    // R9: stray indices change nothing
    wr(5'h07, ctl(2'b01, 5'h00, 5'h00));
    wr(5'h0E, 32'h0000_1500);
    wr(5'h00, 32'h0000_0003);
    wr(5'h1F, 32'h0000_1500);
    wr(5'h1E, 32'h0000_0002);
    wr(5'h08, 32'h0000_0000);
    xfer("R9 stray writes ignored, old low hits", 32'h1000, 5'h00, 1'b1);
    xfer("R9 stray writes ignored, new value misses", 32'h1500, 5'h00, 1'b1);

    // R10: write and transfer in the same cycle
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_idx = 5'h0D; cfg_wr_data = 32'h5000;
    bus_valid = 1'b1; bus_addr = 32'h5000; {bus_type, bus_mod} = 5'h00;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    check("R10 same-cycle uses old bound", bp_hit, model_vec(32'h5000, 5'h00));
    model_write(5'h0D, 32'h5000);
    @(negedge clk);
    check("R10 later cycle uses new bound", bp_hit, model_vec(32'h5000, 5'h00));

    // R11: inverted bounds
    wr(5'h0D, 32'h3000); wr(5'h0C, 32'h2000);
    wr(5'h1D, 32'h3000); wr(5'h1C, 32'h2000);
    wr(5'h07, ctl(2'b10, 5'h00, 5'h00));
    wr(5'h17, ctl(2'b11, 5'h00, 5'h00));
    for (int k = 0; k < 6; k++)
      xfer("R11 inverted bounds", 32'h1000 + 32'(k) * 32'h0800, 5'h00, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule